// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block sets the length of every external bus access. A 12-bit configuration register holds one 3-bit wait-state setting for each of four address regions: I/O space, data space, the upper half of program space and the lower half of program space. When the bus controller starts an access, it gives the region, the most significant address bit and the direction. The block looks up the access length for that setting and holds a stall line high until the programmed count has run out. Only then does it look at the external READY input. It pulses a completion strobe in the first cycle after that point in which READY is high.

Reads take the setting plus one cycle. Writes follow a different table: settings 0 to 7 give 2, 3, 3, 4, 5, 6, 7 and 8 cycles. Settings 1 and 2 therefore give the same write length, and each write is at least as long as the read for the same setting. READY can only make an access longer; it never makes one shorter. The setting is captured when an access begins, so a register write made during an access has no effect on that access.

Top module: `ws_gen_top`

## Requirements
- R1: While reset is asserted and right after it, `cfg_rdata` reads 16'h0FFF, and `stall` and `done` are low. Every setting is 7, so the slowest timing applies.
- R2: A cycle with `cfg_we` high stores `cfg_wdata[11:0]`, and the stored value is visible on `cfg_rdata[11:0]` from the next cycle. `cfg_rdata[15:12]` always reads zero.
- R3: Region selection uses these register bits. `acc_space`=2'b00 (I/O) uses bits 11:9. `acc_space`=2'b01 (data) uses bits 8:6. When `acc_space[1]`=1 (program), bits 5:3 are used if `acc_addr_msb`=1 and bits 2:0 if `acc_addr_msb`=0.
- R4: The access length is the number of cycles from the cycle after the edge that accepted `acc_start` up to and including the `done` cycle. When READY is high, a read (`acc_write`=0) lasts the setting plus 1 cycle.
- R5: When READY is high, a write (`acc_write`=1) lasts 2, 3, 3, 4, 5, 6, 7 or 8 cycles for settings 0 to 7.
- R6: During an access, `stall` is high in every cycle before the `done` cycle. `done` is high for exactly one cycle and is never high at the same time as `stall`.
- R7: READY is ignored until the programmed count has expired. After that, every cycle with READY low adds one cycle to the access, and `done` is only ever high together with READY.
- R8: The setting is captured when the access is accepted. A register write during the access leaves that access's length unchanged.
- R9: An `acc_start` raised while an access is in progress is ignored: it produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration register readback, upper 4 bits zero |
| acc_start | input | 1 | Start of an access; taken only while idle |
| acc_space | input | 2 | 00 I/O, 01 data, 1x program |
| acc_addr_msb | input | 1 | Most significant address bit; selects the program-space half |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| ready | input | 1 | External ready; low stretches the access after the count expires |
| stall | output | 1 | High while the access must be held |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is a register write that lands while an access is in progress. It must leave that access alone and yet take effect for the next one. The stimulus starts a maximum-length write and, in the following cycle, writes zero to every setting. It then measures that access and a later one. A second hard case is a READY that is low both before and after the count expires. The bench holds READY low from the start of the access for a chosen number of cycles beyond the programmed length, so the cycles spent waiting on the counter and the cycles spent waiting on READY can be told apart. A stray start pulse in the middle of a long access is also injected, and the monitor then watches for any `done` that has no access open.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
  typedef enum logic [1:0] {
    SP_IO   = 2'b00,
    SP_DATA = 2'b01,
    SP_PROG = 2'b10
  } space_e;

  localparam int unsigned NUM_FIELDS = 4;
  // field slot index inside the register, lowest slot at bit 0
  localparam int unsigned SLOT_PLO  = 0;
  localparam int unsigned SLOT_PHI  = 1;
  localparam int unsigned SLOT_DATA = 2;
  localparam int unsigned SLOT_IO   = 3;
endpackage

// File: rtl/ws_cfg_reg.sv
`timescale 1ns/1ps
module ws_cfg_reg #(
  parameter int unsigned RW = 16,
  parameter int unsigned FW = 3,
  parameter int unsigned NF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RW-1:0]    wdata,
  output logic [NF*FW-1:0] fields,
  output logic [RW-1:0]    rdata
);
  localparam int unsigned CW = NF * FW;

  logic [CW-1:0] cfg_q;
  logic [CW-1:0] cfg_d;

  always_comb begin
    cfg_d = wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '1;
    end else if (we) begin
      cfg_q <= cfg_d;
    end
  end

  assign fields = cfg_q;
  assign rdata  = {{(RW-CW){1'b0}}, cfg_q};

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata[CW-1:0] == $past(wdata[CW-1:0]))); // R2
endmodule

// File: rtl/ws_len_sel.sv
`timescale 1ns/1ps
module ws_len_sel
  import ws_pkg::*;
#(
  parameter int unsigned FW = 3,
  parameter int unsigned NF = NUM_FIELDS,
  localparam int unsigned LW = FW + 1
) (
  input  logic [NF*FW-1:0] fields,
  input  logic [1:0]       space,
  input  logic             addr_msb,
  input  logic             write,
  output logic [LW-1:0]    len
);
  logic [FW-1:0] slot [NF];

  for (genvar g = 0; g < NF; g++) begin : g_unpack
    assign slot[g] = fields[g*FW +: FW];
  end

  logic [FW-1:0] setting;
  logic [LW-1:0] rd_len;
  logic [LW-1:0] wr_len;

  always_comb begin
    if (space[1]) begin
      setting = addr_msb ? slot[SLOT_PHI] : slot[SLOT_PLO];
    end else if (space[0]) begin
      setting = slot[SLOT_DATA];
    end else begin
      setting = slot[SLOT_IO];
    end
  end

  always_comb begin
    rd_len = LW'(setting) + LW'(1);
    if (setting == '0) begin
      wr_len = LW'(2);
    end else if (setting <= FW'(2)) begin
      wr_len = LW'(3);
    end else begin
      wr_len = LW'(setting) + LW'(1);
    end
    len = write ? wr_len : rd_len;
  end
endmodule

// File: rtl/ws_stall_ctr.sv
`timescale 1ns/1ps
module ws_stall_ctr #(
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] load_len,
  input  logic          ready,
  output logic          busy,
  output logic          stall,
  output logic          done
);
  logic          busy_q, busy_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          expired;
  logic          en;

  assign expired = busy_q && (cnt_q == '0);
  assign done    = expired && ready;
  assign stall   = busy_q && !done;
  assign busy    = busy_q;
  assign en      = start || busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = load_len - LW'(1);
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - LW'(1);
      end
      if (done) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready); // R7
  AST_READY_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !ready && !start) |=> (busy_q && cnt_q == '0)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - LW'(1))); // R6
  AST_HOLD_TILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> busy_q); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy_q); // R6
endmodule

// File: rtl/ws_gen_top.sv
`timescale 1ns/1ps
module ws_gen_top
  import ws_pkg::*;
#(
  parameter int unsigned RW = 16,
  parameter int unsigned FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          acc_start,
  input  logic [1:0]    acc_space,
  input  logic          acc_addr_msb,
  input  logic          acc_write,
  input  logic          ready,
  output logic          stall,
  output logic          done
);
  localparam int unsigned NF = NUM_FIELDS;
  localparam int unsigned CW = NF * FW;
  localparam int unsigned LW = FW + 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  logic [CW-1:0] fields;
  logic [RW-1:0] rdata;
  logic [LW-1:0] len;
  logic          busy;
  logic          accept;

  ws_cfg_reg #(.RW(RW), .FW(FW), .NF(NF)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata[RW-1:0]),
    .fields (fields),
    .rdata  (rdata)
  );

  ws_len_sel #(.FW(FW), .NF(NF)) u_len (
    .fields   (fields),
    .space    (acc_space),
    .addr_msb (acc_addr_msb),
    .write    (acc_write),
    .len      (len)
  );

  assign accept = acc_start && !busy;

  ws_stall_ctr #(.LW(LW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (accept),
    .load_len (len),
    .ready    (ready),
    .busy     (busy),
    .stall    (stall),
    .done     (done)
  );

  assign cfg_rdata = 16'(rdata);

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |-> (len >= LW'(1) && len <= LW'(1 << FW))); // R4
  AST_WRITE_MIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && acc_write) |-> (len >= LW'(2))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !busy |-> (!stall && !done)); // R1
endmodule

// File: tb/tb_ws_gen_top.sv
`timescale 1ns/1ps
module tb_ws_gen_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic [15:0] cfg_rdata;
  logic        acc_start;
  logic [1:0]  acc_space;
  logic        acc_addr_msb;
  logic        acc_write;
  logic        ready;
  logic        stall;
  logic        done;

  always #2.5 clk = ~clk;

  ws_gen_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_start(acc_start), .acc_space(acc_space),
    .acc_addr_msb(acc_addr_msb), .acc_write(acc_write), .ready(ready),
    .stall(stall), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int unexpected_done = 0;
  bit finished = 0;

  int    exp_q[$];
  string tag_q[$];
  bit    mon_active = 0;
  int    mon_cnt = 0;
  bit    stall_ok = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rd_len(input int v);
    return v + 1;
  endfunction

  function automatic int wr_len(input int v);
    if (v == 0) return 2;
    if (v <= 2) return 3;
    return v + 1;
  endfunction

  // monitor: counts cycles of the open access and compares with the scoreboard
  always @(negedge clk) begin
    if (mon_active) begin
      mon_cnt++;
      if (done) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk((mon_cnt - 1) == e, t, mon_cnt - 1, e);
        chk(stall_ok && !stall, "R6", int'(stall_ok), 1);
        mon_active = 0;
      end else begin
        if (mon_cnt >= 2 && !stall) stall_ok = 0;
        if (mon_cnt > 64) begin
          chk(1'b0, t_hang(), mon_cnt, 0);
          mon_active = 0;
        end
      end
    end else if (done) begin
      unexpected_done++;
    end
  end

  function automatic string t_hang();
    return "R7 access never completed";
  endfunction

  task automatic write_cfg(input logic [15:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // mode: 0 plain, 1 register write during access, 2 stray start during access
  task automatic access(input logic [1:0] sp, input logic msb, input logic wr,
                        input int exp_len, input int rlow, input int mode,
                        input string tag);
    acc_space = sp;
    acc_addr_msb = msb;
    acc_write = wr;
    acc_start = 1'b1;
    ready = (rlow > 0) ? 1'b0 : 1'b1;
    exp_q.push_back(exp_len + rlow);
    tag_q.push_back(tag);
    mon_cnt = 0;
    stall_ok = 1;
    mon_active = 1;
    @(posedge clk); #1;
    acc_start = 1'b0;
    if (mode == 1) begin
      write_cfg(16'h0000);
    end else if (mode == 2) begin
      acc_space = 2'b00;
      acc_write = 1'b0;
      acc_start = 1'b1;
      @(posedge clk); #1;
      acc_start = 1'b0;
    end
    if (rlow > 0) begin
      repeat (exp_len + rlow - 1) @(posedge clk);
      #1 ready = 1'b1;
    end
    wait (!mon_active);
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    acc_start = 1'b0;
    acc_space = 2'b00;
    acc_addr_msb = 1'b0;
    acc_write = 1'b0;
    ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 16'h0FFF, "R1 reset cfg", cfg_rdata, 16'h0FFF);
    chk(!stall, "R1 reset stall", stall, 0);
    chk(!done, "R1 reset done", done, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk(cfg_rdata == 16'h0FFF, "R1 after release", cfg_rdata, 16'h0FFF);

    access(2'b00, 1'b0, 1'b0, 8, 0, 0, "R1 default read length");
    access(2'b10, 1'b0, 1'b1, 8, 0, 0, "R1 default write length");

    write_cfg(16'hF123);
    @(negedge clk);
    chk(cfg_rdata == 16'h0123, "R2 readback", cfg_rdata, 16'h0123);
    @(posedge clk); #1;

    for (int v = 0; v < 8; v++) begin
      write_cfg(16'({v[2:0], v[2:0], v[2:0], v[2:0]}));
      access(2'b01, 1'b0, 1'b0, rd_len(v), 0, 0, $sformatf("R4 read setting %0d", v));
      access(2'b01, 1'b0, 1'b1, wr_len(v), 0, 0, $sformatf("R5 write setting %0d", v));
    end

    // I/O=1, data=3, upper program=5, lower program=6
    write_cfg(16'b0000_001_011_101_110);
    access(2'b00, 1'b1, 1'b0, 2, 0, 0, "R3 I/O field");
    access(2'b01, 1'b1, 1'b0, 4, 0, 0, "R3 data field");
    access(2'b10, 1'b1, 1'b0, 6, 0, 0, "R3 upper program field");
    access(2'b10, 1'b0, 1'b0, 7, 0, 0, "R3 lower program field");
    access(2'b11, 1'b1, 1'b0, 6, 0, 0, "R3 space 11 upper program");
    access(2'b00, 1'b0, 1'b1, 3, 0, 0, "R3 I/O write setting 1");

    write_cfg(16'b0000_010_010_010_010);
    access(2'b01, 1'b0, 1'b0, 3, 3, 0, "R7 read stretched by ready");
    write_cfg(16'h0000);
    access(2'b00, 1'b0, 1'b1, 2, 1, 0, "R7 write stretched by ready");
    access(2'b00, 1'b0, 1'b0, 1, 2, 0, "R7 zero-wait read stretched");

    write_cfg(16'h0FFF);
    access(2'b10, 1'b1, 1'b1, 8, 0, 1, "R8 length latched at start");
    @(negedge clk);
    chk(cfg_rdata == 16'h0000, "R8 mid-access write landed", cfg_rdata, 0);
    @(posedge clk); #1;
    access(2'b10, 1'b1, 1'b1, 2, 0, 0, "R8 next access uses new setting");

    write_cfg(16'h0FFF);
    access(2'b01, 1'b0, 1'b0, 8, 0, 2, "R9 access with stray start");
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(unexpected_done == 0, "R9 no extra done", unexpected_done, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule